// File: doc/BRIEF.md
# Serial-Key Timekeeper Access Controller

This block sits on a host memory bus in front of an SRAM and hides a timekeeper behind the RAM address space. By default every bus cycle reaches the RAM. The host can open a path to the clock by first issuing a read cycle and then sixty-four write cycles whose data bit spells a fixed 64-bit key. Each key bit is compared with its own position of the key. One wrong bit locks the matcher until the next read cycle.

Once the whole key has matched, the next sixty-four bus cycles go to the timekeeper instead of the RAM, one bit per cycle. Read cycles return bits from a snapshot that is taken when the transfer opens. Write cycles build up new register contents, and each register byte is handed to the timekeeper as soon as its last bit arrives. After those cycles the bus goes back to the RAM.

A power-fail input keeps the RAM deselected at all times while it is asserted. An abort pin can cancel a match in progress or a transfer in progress, unless a mask bit held in the timekeeper registers says the pin is to be ignored.

Top module: `keyrtc_access`

## Requirements
- R1: The key is the byte sequence C5, 3A, A3, 5C, C5, 3A, A3, 5C, with each byte sent least significant bit first. Key bit i is compared with the data bit of the i-th write cycle. When all 64 key bits have matched, the next bus cycle is steered to the timekeeper and `ramCeN` stays high for the whole of that cycle.
- R2: While the key is being matched, every cycle reaches the RAM, including all 64 key write cycles. `ramCeN` follows `busCeN` during those cycles.
- R3: A write cycle whose data bit differs from the key bit at the current position does not move the position. All later write cycles are ignored until a read cycle occurs, so correct bits sent after a wrong one never open the transfer.
- R4: Any read cycle outside a transfer returns the key position to bit 0 and clears a lockout.
- R5: During a transfer, a read cycle (output enable low, write enable high) drives `dataOut` with `dataOutEn` high. The bits come out in the order bit 0 of register byte 0 through bit 7 of byte 7, where byte k is `clkRegIn[8k+7:8k]`.
- R6: Read data during a transfer comes from a copy of `clkRegIn` taken when the key completes. Later changes on `clkRegIn` do not affect it.
- R7: During a transfer, a write cycle stores its data bit at the current bit index. When the index reaches bit 7 of a byte, `clkByteLoad[k]` pulses for one clock, with `clkRegOut[8k+7:8k]` holding the assembled byte. At most one load bit is high at a time. Bits of a byte that are not written keep the values from the snapshot.
- R8: After 64 transfer cycles, the next cycle reaches the RAM again.
- R9: When `clkRegIn[36]` (the abort mask) is 0, a low level on `abortPinN` cancels matching or a transfer in progress. The next cycle reaches the RAM, and an incomplete byte is not loaded.
- R10: When `clkRegIn[36]` is 1, `abortPinN` has no effect and a transfer in progress continues.
- R11: While `powerFail` is high, `ramCeN` is high.
- R12: With `powerFail` low, `ramCeN` does not switch from enabled to blocked in the middle of a bus cycle. This assumes `busCeN` stays high for at least `SYNC_STAGES`+2 clocks between cycles.
- R13: After reset, the matcher is at bit 0, no transfer is open, `dataOutEn` is low, no load bit is set, and cycles reach the RAM.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Synchronous reset, active low |
| busCeN | input | 1 | Bus chip enable, active low, asynchronous |
| busOeN | input | 1 | Bus output enable, active low, asynchronous |
| busWeN | input | 1 | Bus write enable, active low, asynchronous |
| dataIn | input | 1 | Serial data bit from the host |
| dataOut | output | 1 | Serial data bit to the host during transfer reads |
| dataOutEn | output | 1 | High while `dataOut` is to be driven onto the bus |
| abortPinN | input | 1 | Abort request, active low |
| powerFail | input | 1 | Supply out of tolerance, high active |
| ramCeN | output | 1 | Gated chip enable to the RAM, active low |
| clkRegIn | input | 64 | Current timekeeper register contents, byte k at bits 8k+7:8k |
| clkRegOut | output | 64 | Register contents written through the serial transfer |
| clkByteLoad | output | 8 | One-clock load strobe per register byte |

## Verification
The bench builds the block with its default parameters: a two-stage synchronizer, and the abort mask at bit 36 of the register port. A cycle therefore takes a fixed, short number of clocks to register, so the bench can run several complete unlock-and-transfer sessions, as well as lockout, pointer-reset and abort sequences, each with 64-bit keys. With the abort mask at that position, the bench can turn the abort pin on and off just by choosing the register value it presents.

// File: rtl/keyrtc_pkg.sv
package keyrtc_pkg;

  localparam int REG_BYTES  = 8;
  localparam int XFER_BITS  = REG_BYTES * 8;
  localparam int IDX_W      = $clog2(XFER_BITS);
  localparam int BYTE_SEL_W = IDX_W - 3;

  // serial unlock sequence, bit i is compared with the i-th write cycle
  localparam logic [XFER_BITS-1:0] UNLOCK_KEY = 64'h5CA3_3AC5_5CA3_3AC5;

  // strobes from the control to the datapath
  typedef struct packed {
    logic             startXfer;
    logic             xferStep;
    logic             xferWrite;
    logic             xferRead;
    logic             cycleEnd;
    logic [IDX_W-1:0] bitIdx;
    logic             dataBit;
  } ctl_strobe_t;

endpackage

// File: rtl/keyrtc_bus_sync.sv
module keyrtc_bus_sync #(
  parameter int               WIDTH     = 5,
  parameter int               STAGES    = 2,
  parameter logic [WIDTH-1:0] RESET_VAL = '1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);

  logic [STAGES-1:0][WIDTH-1:0] stageQ;

  always_ff @(posedge clk) begin
    if (!rstN) stageQ <= {STAGES{RESET_VAL}};
    else       stageQ <= {stageQ[STAGES-2:0], asyncIn};
  end

  assign syncOut = stageQ[STAGES-1];

endmodule

// File: rtl/keyrtc_ctrl.sv
module keyrtc_ctrl
  import keyrtc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        busCeN,
  input  logic        busOeN,
  input  logic        busWeN,
  input  logic        dataIn,
  input  logic        abortPinN,
  input  logic        abortMask,
  output logic        ramBlock,
  output ctl_strobe_t ctl
);

  logic [4:0] syncQ;
  logic ceS, oeS, weS, dS, abS;
  logic ceLast, ceFall, ceRise, isWrite, isRead, abortReq, keyHit;
  logic [IDX_W-1:0] keyPtr, xferCnt;
  logic keyJam, xferOn;

  keyrtc_bus_sync #(
    .WIDTH    (5),
    .STAGES   (SYNC_STAGES),
    .RESET_VAL(5'b11111)
  ) u_sync (
    .clk    (clk),
    .rstN   (rstN),
    .asyncIn({busCeN, busOeN, busWeN, dataIn, abortPinN}),
    .syncOut(syncQ)
  );

  assign {ceS, oeS, weS, dS, abS} = syncQ;

  always_comb begin
    ceFall   = ceLast & ~ceS;
    ceRise   = ~ceLast & ceS;
    isWrite  = ~weS;
    isRead   = weS & ~oeS;
    abortReq = ~abS & ~abortMask;
    keyHit   = (dS == UNLOCK_KEY[keyPtr]);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ceLast   <= 1'b1;
      keyPtr   <= '0;
      keyJam   <= 1'b0;
      xferOn   <= 1'b0;
      xferCnt  <= '0;
      ramBlock <= 1'b0;
    end else begin
      ceLast <= ceS;
      // the RAM path only changes between bus cycles
      if (ceS) ramBlock <= xferOn;
      if (abortReq) begin
        keyPtr  <= '0;
        keyJam  <= 1'b0;
        xferOn  <= 1'b0;
        xferCnt <= '0;
      end else if (ceFall) begin
        if (xferOn) begin
          xferCnt <= xferCnt + 1'b1;
          if (xferCnt == IDX_W'(XFER_BITS - 1)) xferOn <= 1'b0;
        end else if (isRead) begin
          keyPtr <= '0;
          keyJam <= 1'b0;
        end else if (isWrite && !keyJam) begin
          if (!keyHit) begin
            keyJam <= 1'b1;
          end else if (keyPtr == IDX_W'(XFER_BITS - 1)) begin
            xferOn  <= 1'b1;
            xferCnt <= '0;
            keyPtr  <= '0;
          end else begin
            keyPtr <= keyPtr + 1'b1;
          end
        end
      end
    end
  end

  always_comb begin
    ctl.startXfer = ~abortReq & ceFall & ~xferOn & isWrite & ~keyJam & keyHit
                    & (keyPtr == IDX_W'(XFER_BITS - 1));
    ctl.xferStep  = ~abortReq & ceFall & xferOn;
    ctl.xferWrite = isWrite;
    ctl.xferRead  = isRead;
    ctl.cycleEnd  = ceRise;
    ctl.bitIdx    = xferCnt;
    ctl.dataBit   = dS;
  end

endmodule

// File: rtl/keyrtc_data.sv
module keyrtc_data
  import keyrtc_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  ctl_strobe_t          ctl,
  input  logic [XFER_BITS-1:0] liveRegs,
  output logic [XFER_BITS-1:0] writeImage,
  output logic [REG_BYTES-1:0] byteLoad,
  output logic                 outBit,
  output logic                 outEn
);

  logic [XFER_BITS-1:0] snapQ, imageQ;
  logic [REG_BYTES-1:0] loadHit;
  logic writeStep;

  assign writeStep = ctl.xferStep & ctl.xferWrite;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      snapQ  <= '0;
      imageQ <= '0;
    end else if (ctl.startXfer) begin
      snapQ  <= liveRegs;
      imageQ <= liveRegs;
    end else if (writeStep) begin
      imageQ[ctl.bitIdx] <= ctl.dataBit;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outBit <= 1'b0;
      outEn  <= 1'b0;
    end else if (ctl.xferStep && ctl.xferRead) begin
      outBit <= snapQ[ctl.bitIdx];
      outEn  <= 1'b1;
    end else if (ctl.cycleEnd) begin
      outEn <= 1'b0;
    end
  end

  for (genvar b = 0; b < REG_BYTES; b++) begin : g_load
    assign loadHit[b] = writeStep && (ctl.bitIdx[2:0] == 3'd7)
                        && (ctl.bitIdx[IDX_W-1:3] == BYTE_SEL_W'(b));
  end

  always_ff @(posedge clk) begin
    if (!rstN) byteLoad <= '0;
    else       byteLoad <= loadHit;
  end

  assign writeImage = imageQ;

endmodule

// File: rtl/keyrtc_access.sv
module keyrtc_access
  import keyrtc_pkg::*;
#(
  parameter int SYNC_STAGES    = 2,
  parameter int ABORT_MASK_BIT = 36
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 busCeN,
  input  logic                 busOeN,
  input  logic                 busWeN,
  input  logic                 dataIn,
  output logic                 dataOut,
  output logic                 dataOutEn,
  input  logic                 abortPinN,
  input  logic                 powerFail,
  output logic                 ramCeN,
  input  logic [XFER_BITS-1:0] clkRegIn,
  output logic [XFER_BITS-1:0] clkRegOut,
  output logic [REG_BYTES-1:0] clkByteLoad
);

  ctl_strobe_t ctl;
  logic ramBlock;

  keyrtc_ctrl #(
    .SYNC_STAGES(SYNC_STAGES)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .busCeN   (busCeN),
    .busOeN   (busOeN),
    .busWeN   (busWeN),
    .dataIn   (dataIn),
    .abortPinN(abortPinN),
    .abortMask(clkRegIn[ABORT_MASK_BIT]),
    .ramBlock (ramBlock),
    .ctl      (ctl)
  );

  keyrtc_data u_data (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .liveRegs  (clkRegIn),
    .writeImage(clkRegOut),
    .byteLoad  (clkByteLoad),
    .outBit    (dataOut),
    .outEn     (dataOutEn)
  );

  assign ramCeN = busCeN | powerFail | ramBlock;

endmodule

// File: rtl/keyrtc_access_chk.sv
module keyrtc_access_chk (
  input logic       clk,
  input logic       rstN,
  input logic       busCeN,
  input logic       powerFail,
  input logic       ramCeN,
  input logic       dataOutEn,
  input logic [7:0] clkByteLoad
);

  // R11
  power_fail_block_chk: assert property (@(posedge clk) disable iff (!rstN)
    powerFail |-> ramCeN);

  // R5
  drive_isolated_chk: assert property (@(posedge clk) disable iff (!rstN)
    dataOutEn |-> ramCeN);

  // R7
  byte_load_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(clkByteLoad));

  // R7
  load_in_divert_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|clkByteLoad) |-> ramCeN);

  // R12
  no_midcycle_block_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!busCeN && $past(!busCeN) && !powerFail && $past(!powerFail)) |-> !$rose(ramCeN));

endmodule

bind keyrtc_access keyrtc_access_chk u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .busCeN     (busCeN),
  .powerFail  (powerFail),
  .ramCeN     (ramCeN),
  .dataOutEn  (dataOutEn),
  .clkByteLoad(clkByteLoad)
);

// File: tb/test_keyrtc_access.sv
module test_keyrtc_access;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rstN = 1'b0;
  logic        busCeN = 1'b1, busOeN = 1'b1, busWeN = 1'b1, dataIn = 1'b0;
  logic        abortPinN = 1'b1, powerFail = 1'b0;
  logic        dataOut, dataOutEn, ramCeN;
  logic [63:0] clkRegIn = '0;
  logic [63:0] clkRegOut;
  logic [7:0]  clkByteLoad;

  keyrtc_access i_keyrtc_access (
    .clk(clk), .rstN(rstN), .busCeN(busCeN), .busOeN(busOeN), .busWeN(busWeN),
    .dataIn(dataIn), .dataOut(dataOut), .dataOutEn(dataOutEn), .abortPinN(abortPinN),
    .powerFail(powerFail), .ramCeN(ramCeN), .clkRegIn(clkRegIn), .clkRegOut(clkRegOut),
    .clkByteLoad(clkByteLoad)
  );

  int checks = 0, errors = 0, midFlip = 0, loadCnt = 0;
  bit done = 1'b0;
  logic [7:0] captured [8];

  localparam logic [7:0] KEY_BYTES [8] = '{8'hC5, 8'h3A, 8'hA3, 8'h5C, 8'hC5, 8'h3A, 8'hA3, 8'h5C};
  localparam int N_VEC = 3;
  localparam logic [63:0] READ_VECS [N_VEC] = '{
    64'h2412_0516_0734_5921, 64'h9912_3101_1159_5999, 64'h0001_0203_0405_0607};

  function automatic logic keyBit(int i);
    return KEY_BYTES[i / 8][i % 8];
  endfunction

  always @(negedge clk) begin
    for (int b = 0; b < 8; b++) begin
      if (clkByteLoad[b]) begin
        loadCnt++;
        captured[b] = clkRegOut[8*b +: 8];
      end
    end
  end

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic busCycle(input bit wr, input bit rd, input bit d,
                          output bit ramSel, output bit oEn, output bit oBit);
    logic early;
    @(negedge clk); busWeN = !wr; busOeN = !rd; dataIn = d;
    @(negedge clk); busCeN = 1'b0;
    @(negedge clk); early = ramCeN;
    repeat (3) @(negedge clk);
    ramSel = !ramCeN; oEn = dataOutEn; oBit = dataOut;
    if (early !== ramCeN && !powerFail) midFlip++;
    repeat (2) @(negedge clk); busCeN = 1'b1;
    repeat (4) @(negedge clk); busWeN = 1'b1; busOeN = 1'b1;
  endtask

  task automatic sendKey(output bit allRam);
    bit s, e, o;
    allRam = 1'b1;
    busCycle(1'b0, 1'b1, 1'b0, s, e, o);
    allRam &= s;
    for (int i = 0; i < 64; i++) begin
      busCycle(1'b1, 1'b0, keyBit(i), s, e, o);
      allRam &= s;
    end
  endtask

  task automatic readXfer(output logic [63:0] got, output bit anyRam, output bit allEn);
    bit s, e, o;
    anyRam = 1'b0; allEn = 1'b1; got = '0;
    for (int i = 0; i < 64; i++) begin
      busCycle(1'b0, 1'b1, 1'b0, s, e, o);
      got[i] = o; anyRam |= s; allEn &= e;
    end
  endtask

  task automatic writeXfer(input logic [63:0] v, output bit anyRam);
    bit s, e, o;
    anyRam = 1'b0;
    for (int i = 0; i < 64; i++) begin
      busCycle(1'b1, 1'b0, v[i], s, e, o);
      anyRam |= s;
    end
  endtask

  task automatic abortPulse();
    @(negedge clk); abortPinN = 1'b0;
    repeat (5) @(negedge clk);
    abortPinN = 1'b1;
    repeat (5) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL R13 watchdog actual=%0d expected=%0d", 1, 0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    bit s, e, o, allRam, anyRam, allEn;
    logic [63:0] got, asm;
    int l0;
    logic [63:0] wv;

    // R13: reset state
    repeat (5) @(negedge clk);
    check(ramCeN === 1'b1, "R13 ramCeN in reset", 64'(ramCeN), 64'd1);
    check(dataOutEn === 1'b0 && clkByteLoad === 8'h00, "R13 outputs idle",
          {55'd0, dataOutEn, clkByteLoad}, 64'd0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    busCycle(1'b0, 1'b1, 1'b0, s, e, o);
    check(s && !e, "R13 first cycle to RAM", {62'd0, s, e}, 64'd2);

    // R1 R2 R5 R6 R8: vector walk
    for (int v = 0; v < N_VEC; v++) begin
      clkRegIn = READ_VECS[v];
      sendKey(allRam);
      check(allRam, "R2 key cycles reach RAM", 64'(allRam), 64'd1);
      clkRegIn = ~READ_VECS[v];
      readXfer(got, anyRam, allEn);
      check(!anyRam, "R1 transfer cycles diverted", 64'(anyRam), 64'd0);
      check(allEn, "R5 dataOutEn on transfer reads", 64'(allEn), 64'd1);
      check(got === READ_VECS[v], "R5 R6 serial read data", got, READ_VECS[v]);
      busCycle(1'b0, 1'b1, 1'b0, s, e, o);
      check(s && !e, "R8 back to RAM after transfer", {62'd0, s, e}, 64'd2);
    end

    // R7: write transfer
    clkRegIn = '0;
    wv = 64'hA5C3_FF00_817E_123C;
    l0 = loadCnt;
    sendKey(allRam);
    writeXfer(wv, anyRam);
    repeat (2) @(negedge clk);
    check(!anyRam, "R7 write cycles diverted", 64'(anyRam), 64'd0);
    check(loadCnt - l0 == 8, "R7 one load per byte", 64'(loadCnt - l0), 64'd8);
    for (int b = 0; b < 8; b++) asm[8*b +: 8] = captured[b];
    check(asm === wv, "R7 loaded bytes", asm, wv);
    check(clkRegOut === wv, "R7 write image", clkRegOut, wv);
    busCycle(1'b1, 1'b0, 1'b0, s, e, o);
    check(s, "R8 RAM after write transfer", 64'(s), 64'd1);

    // R3: mismatch lockout
    busCycle(1'b0, 1'b1, 1'b0, s, e, o);
    allRam = 1'b1;
    for (int i = 0; i < 64; i++) begin
      busCycle(1'b1, 1'b0, (i == 10) ? !keyBit(i) : keyBit(i), s, e, o);
      allRam &= s;
    end
    busCycle(1'b1, 1'b0, 1'b0, s, e, o);
    check(allRam && s, "R3 locked after wrong bit", {62'd0, allRam, s}, 64'd3);

    // R4: read resets pointer mid-key
    busCycle(1'b0, 1'b1, 1'b0, s, e, o);
    for (int i = 0; i < 20; i++) busCycle(1'b1, 1'b0, keyBit(i), s, e, o);
    busCycle(1'b0, 1'b1, 1'b0, s, e, o);
    for (int i = 0; i < 64; i++) busCycle(1'b1, 1'b0, keyBit(i), s, e, o);
    clkRegIn = 64'h0000_0000_0000_0001;
    readXfer(got, anyRam, allEn);
    check(!anyRam, "R4 key accepted after read reset", 64'(anyRam), 64'd0);
    busCycle(1'b0, 1'b1, 1'b0, s, e, o);
    check(s, "R4 RAM after drain", 64'(s), 64'd1);

    // R9: abort honoured when mask bit is 0
    clkRegIn = '0;
    sendKey(allRam);
    l0 = loadCnt;
    for (int i = 0; i < 5; i++) busCycle(1'b1, 1'b0, 1'b1, s, e, o);
    abortPulse();
    busCycle(1'b0, 1'b1, 1'b0, s, e, o);
    check(s, "R9 abort returns to RAM", 64'(s), 64'd1);
    check(loadCnt == l0, "R9 no partial byte load", 64'(loadCnt - l0), 64'd0);

    // R10: abort ignored when mask bit is 1
    clkRegIn = 64'd1 << 36;
    sendKey(allRam);
    for (int i = 0; i < 3; i++) busCycle(1'b0, 1'b1, 1'b0, s, e, o);
    abortPulse();
    busCycle(1'b0, 1'b1, 1'b0, s, e, o);
    check(!s, "R10 abort pin ignored", 64'(s), 64'd0);
    for (int i = 0; i < 60; i++) busCycle(1'b0, 1'b1, 1'b0, s, e, o);
    busCycle(1'b0, 1'b1, 1'b0, s, e, o);
    check(s, "R10 RAM after full transfer", 64'(s), 64'd1);

    // R11: power fail blocks RAM
    powerFail = 1'b1;
    busCycle(1'b0, 1'b1, 1'b0, s, e, o);
    check(!s, "R11 RAM blocked on power fail", 64'(s), 64'd0);
    powerFail = 1'b0;
    busCycle(1'b0, 1'b1, 1'b0, s, e, o);
    check(s, "R11 RAM restored", 64'(s), 64'd1);

    // R12: no mid-cycle switching observed
    check(midFlip == 0, "R12 ramCeN steady within cycles", 64'(midFlip), 64'd0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule